// File: doc/BRIEF.md
# Multiplexed BCD Counter Display

This block is a multi-digit decimal counter that shows its own value on a multiplexed seven-segment display. Each digit of the count sits in its own four-bit storage cell as a BCD value. The block runs one endless loop. A single cycle increments the whole stored number. A scan then puts every digit, least significant first, onto one shared set of segment lines.

A one-hot shift register drives the digit-select lines. It is loaded with a single 1 at the start of each scan, and it moves one place for every digit. Between digits the segment lines are held dark for one cycle, which stops the previous pattern from showing on the next digit. Each eight-bit segment pattern leaves the block on two four-bit ports: one carries the low half and the other the high half. A write port lets surrounding logic replace any stored digit, and counting carries on from the new value.

Top module: `bcd_scan_counter`

## Requirements
- R1: While `rst_n` is low, `dig_sel`, `seg_lo` and `seg_hi` are all 0 and the stored count is cleared. The first scan after reset therefore shows the value 1.
- R2: Each pass takes 1 + NUM_DIGITS*(DWELL_CYCLES+1) cycles. The first is an increment cycle in which `dig_sel` and both segment ports are 0. The scan of digits 0 (least significant) up to NUM_DIGITS-1 follows it.
- R3: The increment adds one decimal unit. A digit holding 9 or more becomes 0 and carries into the next digit up. All nines wrap to all zeros.
- R4: `dig_sel` has at most one bit set. It becomes 1 (bit 0) at the start of a scan, shifts left by exactly one place per digit, and returns to 0 after the last digit.
- R5: Each digit slot begins with one blank cycle, in which `dig_sel` already shows the new digit and both segment ports are 0. DWELL_CYCLES cycles that show the digit's pattern follow it.
- R6: The segment code has bit 0 = a through bit 6 = g, and bit 7 = decimal point. `seg_lo` carries bits 3:0 and `seg_hi` carries bits 7:4. The codes for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R7: A digit holding 10 to 15 is shown with all segments off. The decimal-point bit (`seg_hi[3]`) is always 0.
- R8: When `wr_en` is high at a clock edge, `wr_digit` is stored into digit `wr_idx`. The next increment starts from the written value.
- R9: A write made during the increment cycle stores the written digit, and no increment takes place in that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Digit write strobe |
| wr_idx | input | IDX_W | Index of the digit to write (0 = least significant) |
| wr_digit | input | 4 | Value to store |
| seg_lo | output | 4 | Segment code bits 3:0 (a, b, c, d), active high |
| seg_hi | output | 4 | Segment code bits 7:4 (e, f, g, decimal point), active high |
| dig_sel | output | NUM_DIGITS | One-hot digit select, active high |

## Verification
The block's outputs are set by its registers alone. In any cycle, `dig_sel` and the segment ports follow from the phase and count reached at the preceding edge. A write is taken at the edge where `wr_en` is high, and it shows in the pass that begins at the next increment cycle, or in the current pass if the write falls in the increment cycle. The bench therefore predicts one expected item per cycle for a whole pass, starting on the increment cycle: one item for the increment cycle, then one blank cycle and DWELL_CYCLES segment cycles per digit. Because internal reset release takes two edges, the first prediction is aligned to the cycle after the second rising edge following reset release. All outputs are sampled two nanoseconds after the falling edge.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

  typedef enum logic [1:0] {
    PH_INC  = 2'd0,
    PH_GAP  = 2'd1,
    PH_SHOW = 2'd2
  } scan_phase_e;

  // Segment map: bit0=a .. bit6=g, bit7=decimal point (always off)
  function automatic logic [7:0] seg_code(input logic [3:0] d);
    logic [7:0] c;
    case (d)
      4'd0:    c = 8'h3F;
      4'd1:    c = 8'h06;
      4'd2:    c = 8'h5B;
      4'd3:    c = 8'h4F;
      4'd4:    c = 8'h66;
      4'd5:    c = 8'h6D;
      4'd6:    c = 8'h7D;
      4'd7:    c = 8'h07;
      4'd8:    c = 8'h7F;
      4'd9:    c = 8'h6F;
      default: c = 8'h00;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bcd_scan_incr.sv
module bcd_scan_incr #(
  parameter int NUM_DIGITS = 4
) (
  input  logic [NUM_DIGITS-1:0][3:0] cur,
  output logic [NUM_DIGITS-1:0][3:0] nxt
);
  // Ripple decimal carry, least significant digit first (R3)
  always_comb begin
    logic carry;
    carry = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (!carry) begin
        nxt[i] = cur[i];
      end else if (cur[i] >= 4'd9) begin
        nxt[i] = 4'd0;
      end else begin
        nxt[i] = cur[i] + 4'd1;
        carry  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
  import bcd_scan_pkg::*;
(
  input  logic [3:0] digit,
  input  logic       show,
  output logic [7:0] code
);
  always_comb begin
    code = show ? seg_code(digit) : 8'h00;
  end
endmodule

// File: rtl/bcd_scan_ctrl.sv
module bcd_scan_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS   = 4,
  parameter int DWELL_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  inc_en,
  output logic                  show_en,
  output logic [NUM_DIGITS-1:0] sel
);
  localparam int DWELL_W = $clog2(DWELL_CYCLES) + 1;
  localparam logic [DWELL_W-1:0] DWELL_LAST = DWELL_W'(DWELL_CYCLES - 1);

  scan_phase_e           phase_q, phase_d;
  logic [NUM_DIGITS-1:0] sel_q, sel_d;
  logic                  sel_en;
  logic [DWELL_W-1:0]    dwell_q, dwell_d;
  logic                  dwell_en;

  always_comb begin
    phase_d  = phase_q;
    sel_d    = sel_q;
    sel_en   = 1'b0;
    dwell_d  = dwell_q;
    dwell_en = 1'b0;
    case (phase_q)
      PH_INC: begin
        sel_d    = NUM_DIGITS'(1);
        sel_en   = 1'b1;
        dwell_d  = '0;
        dwell_en = 1'b1;
        phase_d  = PH_GAP;
      end
      PH_GAP: begin
        dwell_d  = '0;
        dwell_en = 1'b1;
        phase_d  = PH_SHOW;
      end
      PH_SHOW: begin
        dwell_en = 1'b1;
        if (dwell_q == DWELL_LAST) begin
          dwell_d = '0;
          sel_en  = 1'b1;
          if (sel_q[NUM_DIGITS-1]) begin
            sel_d   = '0;
            phase_d = PH_INC;
          end else begin
            sel_d   = sel_q << 1;
            phase_d = PH_GAP;
          end
        end else begin
          dwell_d = dwell_q + DWELL_W'(1);
        end
      end
      default: phase_d = PH_INC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_INC;
      sel_q   <= '0;
      dwell_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (sel_en)   sel_q   <= sel_d;
      if (dwell_en) dwell_q <= dwell_d;
    end
  end

  assign inc_en  = (phase_q == PH_INC);
  assign show_en = (phase_q == PH_SHOW);
  assign sel     = sel_q;
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter #(
  parameter int NUM_DIGITS   = 4,
  parameter int DWELL_CYCLES = 4,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [3:0]            wr_digit,
  output logic [3:0]            seg_lo,
  output logic [3:0]            seg_hi,
  output logic [NUM_DIGITS-1:0] dig_sel
);
  // Reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic                  inc_en, show_en;
  logic [NUM_DIGITS-1:0] sel;

  bcd_scan_ctrl #(
    .NUM_DIGITS  (NUM_DIGITS),
    .DWELL_CYCLES(DWELL_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .inc_en (inc_en),
    .show_en(show_en),
    .sel    (sel)
  );

  // Digit storage
  logic [NUM_DIGITS-1:0][3:0] digits_q, digits_d, digits_inc;
  logic                       digits_en;

  bcd_scan_incr #(.NUM_DIGITS(NUM_DIGITS)) i_incr (
    .cur(digits_q),
    .nxt(digits_inc)
  );

  always_comb begin
    digits_d  = digits_q;
    digits_en = 1'b0;
    if (wr_en) begin
      // a write wins over the increment of the same cycle (R9)
      if (int'(wr_idx) < NUM_DIGITS) begin
        digits_d[wr_idx] = wr_digit;
        digits_en        = 1'b1;
      end
    end else if (inc_en) begin
      digits_d  = digits_inc;
      digits_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      digits_q <= '0;
    end else if (digits_en) begin
      digits_q <= digits_d;
    end
  end

  // One-hot AND-OR selection of the active digit
  logic [3:0] cur_digit;
  always_comb begin
    cur_digit = 4'd0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (sel[i]) cur_digit = cur_digit | digits_q[i];
    end
  end

  logic [7:0] code;
  bcd_seg_decode i_dec (
    .digit(cur_digit),
    .show (show_en),
    .code (code)
  );

  assign seg_lo  = code[3:0];
  assign seg_hi  = code[7:4];
  assign dig_sel = sel;
endmodule

// File: rtl/bcd_scan_counter_chk.sv
module bcd_scan_counter_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [3:0]            seg_lo,
  input logic [3:0]            seg_hi,
  input logic [NUM_DIGITS-1:0] dig_sel
);
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dig_sel));

  assert_scan_from_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dig_sel) == '0 && dig_sel != '0) |-> dig_sel == NUM_DIGITS'(1));

  assert_single_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dig_sel) != '0 && dig_sel != '0 && !$stable(dig_sel))
      |-> dig_sel == ($past(dig_sel) << 1));

  assert_dark_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_sel == '0) |-> ({seg_hi, seg_lo} == 8'h00));

  assert_blank_on_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dig_sel) && dig_sel != '0) |-> ({seg_hi, seg_lo} == 8'h00));

  assert_dp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seg_hi[3] == 1'b0);
endmodule

bind bcd_scan_counter bcd_scan_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .seg_lo (seg_lo),
  .seg_hi (seg_hi),
  .dig_sel(dig_sel)
);

// File: tb/test_bcd_scan_counter.sv
module test_bcd_scan_counter;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int IW = 2;
  localparam int P  = 1 + N * (D + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [3:0]    wr_digit;
  logic [3:0]    seg_lo, seg_hi;
  logic [N-1:0]  dig_sel;

  bcd_scan_counter #(.NUM_DIGITS(N), .DWELL_CYCLES(D)) i_bcd_scan_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_digit(wr_digit), .seg_lo(seg_lo), .seg_hi(seg_hi), .dig_sel(dig_sel)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [N-1:0] sel;
    logic [7:0]   seg;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  int   digs[N];
  bit   pend = 1'b0;
  int   pend_idx, pend_val;

  function automatic logic [7:0] code_of(int v);
    case (v)
      0: return 8'h3F;  1: return 8'h06;  2: return 8'h5B;  3: return 8'h4F;
      4: return 8'h66;  5: return 8'h6D;  6: return 8'h7D;  7: return 8'h07;
      8: return 8'h7F;  9: return 8'h6F;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_on && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, 32'({dig_sel, seg_hi, seg_lo}), 32'({e.sel, e.seg}));
      end
    end
  end

  // Driver: called at the falling edge of an increment cycle
  task automatic do_pass(string tag, bit inc_wr, int iidx, int ival,
                         bit post_wr, int pidx, int pval);
    exp_t e;
    if (pend) begin
      digs[pend_idx] = pend_val;
      pend = 1'b0;
    end
    if (inc_wr) begin
      digs[iidx] = ival;                       // R9: no increment
    end else begin
      bit c = 1'b1;                            // R3 model
      for (int i = 0; i < N; i++) begin
        if (c) begin
          if (digs[i] >= 9) digs[i] = 0;
          else begin digs[i] = digs[i] + 1; c = 1'b0; end
        end
      end
    end
    e.sel = '0; e.seg = 8'h00; e.tag = {"R2 increment cycle ", tag};
    q.push_back(e);
    for (int i = 0; i < N; i++) begin
      e.sel = N'(1) << i; e.seg = 8'h00; e.tag = {"R5 gap ", tag};
      q.push_back(e);
      for (int k = 0; k < D; k++) begin
        e.sel = N'(1) << i; e.seg = code_of(digs[i]);
        e.tag = {"R4 R6 digit ", tag};
        q.push_back(e);
      end
    end
    if (inc_wr) begin
      wr_en = 1'b1; wr_idx = IW'(iidx); wr_digit = 4'(ival);
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (P - 2) @(negedge clk);
    if (post_wr) begin
      wr_en = 1'b1; wr_idx = IW'(pidx); wr_digit = 4'(pval);
      pend = 1'b1; pend_idx = pidx; pend_val = pval;
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) digs[i] = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_digit = '0;
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset outputs", 32'({dig_sel, seg_hi, seg_lo}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    mon_on = 1'b1;

    do_pass("R1 first pass",    0, 0, 0,  0, 0, 0);   // 0001
    do_pass("count",            0, 0, 0,  0, 0, 0);   // 0002
    do_pass("R9 write d3",      1, 3, 9,  0, 0, 0);   // 9002
    do_pass("R9 write d2",      1, 2, 9,  0, 0, 0);   // 9902
    do_pass("R9 write d1",      1, 1, 9,  0, 0, 0);   // 9992
    do_pass("R9 write d0",      1, 0, 8,  0, 0, 0);   // 9998
    do_pass("R3 to nines",      0, 0, 0,  0, 0, 0);   // 9999
    do_pass("R3 wrap",          0, 0, 0,  0, 0, 0);   // 0000
    do_pass("R8 before write",  0, 0, 0,  1, 0, 5);   // 0001, then d0=5
    do_pass("R8 after write",   0, 0, 0,  0, 0, 0);   // 0006
    do_pass("R7 invalid shown", 1, 1, 12, 0, 0, 0);   // d1=12 blank
    do_pass("R7 invalid held",  0, 0, 0,  1, 0, 11);  // d0=7, then d0=11
    do_pass("R3 R7 invalid carry", 0, 0, 0, 0, 0, 0); // 0100

    @(negedge clk);
    #3;
    check("R2 every predicted cycle observed", 32'(q.size()), 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule